// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Status and Mask

This block keeps the interrupt bookkeeping for a two-channel serial controller. One 8-bit status byte records pending events. Each channel owns one nibble of it, holding transmitter-ready, receiver-ready and break-change flags. The two nibbles also carry a shared counter-ready flag and a shared input-port change flag. An 8-bit mask byte uses the same bit positions and selects which pending events may request service.

Neighbouring blocks deliver events as one-cycle pulses. They deliver the clear side effects of register reads and channel commands as strobes. Software reads the status and writes the mask over a small register bus. A single active-high interrupt request is formed from the masked status. Transmitter-ready events are further gated by the channel's transmitter enable.

Top module: `isr_unit`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, status, mask and `irq` all read zero.
- R2: An event pulse sets its status bit at the next clock edge. The bit positions are: transmitter ready at 4*c+0, receiver ready at 4*c+1 and break change at 4*c+2 for channel c (A=0, B=1). Counter ready is at bit 3 and input-port change is at bit 7. A status bit that is neither set nor cleared keeps its value.
- R3: A bus write with `busAddr`=1 loads the mask from `busWdata` at the next edge. `busRdata` shows the mask when `busAddr`=1 and the status when `busAddr`=0. A bus write with `busAddr`=0 leaves the status unchanged.
- R4: `rxReadStb[c]` clears receiver ready of channel c (bit 4*c+1) and no other bit.
- R5: `brkClrCmd[c]` clears break change of channel c (bit 4*c+2) and no other bit.
- R6: `chgReadStb` clears the input-port change bit (bit 7). `ctrClrStb` clears counter ready (bit 3).
- R7: `txBusyStb[c]` clears transmitter ready of channel c (bit 4*c+0).
- R8: When an event and a clear strobe hit the same bit in one cycle, the bit ends up set.
- R9: `irq` is 1 in the cycle after a cycle in which some status bit and its mask bit were both 1. For a transmitter-ready bit, the channel's `txEnable` must also have been 1 in that cycle. Otherwise `irq` is 0.
- R10: A pending, unmasked transmitter-ready bit whose channel has `txEnable` low raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txRdyEvt | input | 2 | Per-channel transmitter-ready event pulse |
| rxRdyEvt | input | 2 | Per-channel receiver-ready event pulse |
| brkChgEvt | input | 2 | Per-channel break-change event pulse |
| ctrRdyEvt | input | 1 | Counter-ready event pulse |
| portChgEvt | input | 1 | Input-port change event pulse |
| txEnable | input | 2 | Per-channel transmitter enable level |
| rxReadStb | input | 2 | Receive holding register read, per channel |
| brkClrCmd | input | 2 | Break-change reset command, per channel |
| txBusyStb | input | 2 | Transmitter-ready clear, per channel |
| ctrClrStb | input | 1 | Counter start/stop clear |
| chgReadStb | input | 1 | Input-port change register read |
| busAddr | input | 1 | 0 selects status, 1 selects mask |
| busWr | input | 1 | Bus write strobe |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check the following. A set event lands in the status. A clear without a competing set removes the bit. Untouched bits hold. A mask write takes the written value. A request is only raised after some status bit met its mask bit. Only the bench scenarios show two further things: the exact bit position of each event and each clear strobe, and the transmitter-enable gating of the request. The bench compares against an independent model on every clock to show these.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int ISR_W = 8;
  localparam int ISR_CH = 2;

  typedef struct packed {
    logic [ISR_W-1:0] setVec;
    logic [ISR_W-1:0] clrVec;
    logic [ISR_W-1:0] gateVec;
    logic             maskWr;
    logic [ISR_W-1:0] maskData;
  } isrStrobes_t;
endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
#(
  parameter int NUM_CH = ISR_CH,
  parameter int DATA_W = ISR_W
) (
  input  logic [NUM_CH-1:0] txRdyEvt,
  input  logic [NUM_CH-1:0] rxRdyEvt,
  input  logic [NUM_CH-1:0] brkChgEvt,
  input  logic              ctrRdyEvt,
  input  logic              portChgEvt,
  input  logic [NUM_CH-1:0] txEnable,
  input  logic [NUM_CH-1:0] rxReadStb,
  input  logic [NUM_CH-1:0] brkClrCmd,
  input  logic [NUM_CH-1:0] txBusyStb,
  input  logic              ctrClrStb,
  input  logic              chgReadStb,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output isrStrobes_t       stb
);
  localparam int STRIDE = DATA_W / NUM_CH;
  localparam int TX_OFS = 0;
  localparam int RX_OFS = 1;
  localparam int BK_OFS = 2;
  localparam int CTR_BIT = STRIDE - 1;
  localparam int CHG_BIT = DATA_W - 1;

  logic [DATA_W-1:0] chSet, chClr, chGate;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      chSet[c*STRIDE +: STRIDE] = '0;
      chClr[c*STRIDE +: STRIDE] = '0;
      chGate[c*STRIDE +: STRIDE] = '1;
      chSet[c*STRIDE + TX_OFS] = txRdyEvt[c];
      chSet[c*STRIDE + RX_OFS] = rxRdyEvt[c];
      chSet[c*STRIDE + BK_OFS] = brkChgEvt[c];
      chClr[c*STRIDE + TX_OFS] = txBusyStb[c];
      chClr[c*STRIDE + RX_OFS] = rxReadStb[c];
      chClr[c*STRIDE + BK_OFS] = brkClrCmd[c];
      chGate[c*STRIDE + TX_OFS] = txEnable[c];
    end
  end

  always_comb begin
    stb.setVec = chSet;
    stb.clrVec = chClr;
    stb.setVec[CTR_BIT] = ctrRdyEvt;
    stb.setVec[CHG_BIT] = portChgEvt;
    stb.clrVec[CTR_BIT] = ctrClrStb;
    stb.clrVec[CHG_BIT] = chgReadStb;
    stb.gateVec = chGate;
    stb.maskWr = busWr & busAddr;
    stb.maskData = busWdata;
  end
endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
#(
  parameter int DATA_W = ISR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  isrStrobes_t       stb,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] maskQ,
  output logic              irqQ
);
  logic [DATA_W-1:0] statusD;
  logic              pendAny;

  always_comb begin
    statusD = (statusQ & ~stb.clrVec) | stb.setVec;
    pendAny = |(statusQ & maskQ & stb.gateVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ <= '0;
      irqQ <= 1'b0;
    end else begin
      statusQ <= statusD;
      irqQ <= pendAny;
      if (stb.maskWr) maskQ <= stb.maskData;
    end
  end

  p_set_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(stb.setVec)) == $past(stb.setVec)));
  p_clear_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(stb.clrVec & ~stb.setVec)) == '0));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((statusQ ^ $past(statusQ)) & ~$past(stb.setVec | stb.clrVec)) == '0));
  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.maskWr |=> (maskQ == $past(stb.maskData)));
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> ($past(statusQ & maskQ) != '0));
endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] txRdyEvt,
  input  logic [1:0] rxRdyEvt,
  input  logic [1:0] brkChgEvt,
  input  logic       ctrRdyEvt,
  input  logic       portChgEvt,
  input  logic [1:0] txEnable,
  input  logic [1:0] rxReadStb,
  input  logic [1:0] brkClrCmd,
  input  logic [1:0] txBusyStb,
  input  logic       ctrClrStb,
  input  logic       chgReadStb,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq
);
  isrStrobes_t stb;
  logic [ISR_W-1:0] statusQ, maskQ;

  isr_ctrl #(.NUM_CH(ISR_CH), .DATA_W(ISR_W)) u_ctrl (
    .txRdyEvt(txRdyEvt), .rxRdyEvt(rxRdyEvt), .brkChgEvt(brkChgEvt),
    .ctrRdyEvt(ctrRdyEvt), .portChgEvt(portChgEvt), .txEnable(txEnable),
    .rxReadStb(rxReadStb), .brkClrCmd(brkClrCmd), .txBusyStb(txBusyStb),
    .ctrClrStb(ctrClrStb), .chgReadStb(chgReadStb), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .stb(stb)
  );

  isr_datapath #(.DATA_W(ISR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .statusQ(statusQ), .maskQ(maskQ), .irqQ(irq)
  );

  assign busRdata = busAddr ? maskQ : statusQ;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> (statusQ == '0 && maskQ == '0 && !irq));
endmodule

// File: tb/isr_unit_tb.sv
module isr_unit_tb;
  logic clk = 0, rstN = 0;
  logic [1:0] txRdyEvt = 0, rxRdyEvt = 0, brkChgEvt = 0, txEnable = 0;
  logic [1:0] rxReadStb = 0, brkClrCmd = 0, txBusyStb = 0;
  logic ctrRdyEvt = 0, portChgEvt = 0, ctrClrStb = 0, chgReadStb = 0;
  logic busAddr = 0, busWr = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic irq;
  int checks = 0, errors = 0;
  int statM = 0, maskM = 0, irqM = 0;

  always #2 clk = ~clk;

  isr_unit u_dut (.*);

  // behavioural reference model
  always @(posedge clk) begin
    int setv, clrv, gatev;
    if (!rstN) begin
      statM = 0; maskM = 0; irqM = 0;
    end else begin
      gatev = 8'hFF;
      if (!txEnable[0]) gatev = gatev & ~1;
      if (!txEnable[1]) gatev = gatev & ~16;
      irqM = ((statM & maskM & gatev) != 0) ? 1 : 0;
      setv = txRdyEvt[0] * 1 + rxRdyEvt[0] * 2 + brkChgEvt[0] * 4 + ctrRdyEvt * 8
           + txRdyEvt[1] * 16 + rxRdyEvt[1] * 32 + brkChgEvt[1] * 64 + portChgEvt * 128;
      clrv = txBusyStb[0] * 1 + rxReadStb[0] * 2 + brkClrCmd[0] * 4 + ctrClrStb * 8
           + txBusyStb[1] * 16 + rxReadStb[1] * 32 + brkClrCmd[1] * 64 + chgReadStb * 128;
      statM = ((statM & ~clrv) | setv) & 255;
      if (busWr && busAddr) maskM = busWdata;
    end
  end

  task automatic clearIns();
    txRdyEvt = 0; rxRdyEvt = 0; brkChgEvt = 0; ctrRdyEvt = 0; portChgEvt = 0;
    rxReadStb = 0; brkClrCmd = 0; txBusyStb = 0; ctrClrStb = 0; chgReadStb = 0;
    busWr = 0; busWdata = 0;
  endtask

  task automatic tick(string tag);
    int expRd;
    @(posedge clk); #1;
    expRd = busAddr ? maskM : statM;
    checks++;
    if (busRdata !== expRd[7:0]) begin
      errors++;
      $display("FAIL %s busRdata actual=%h expected=%h", tag, busRdata, expRd[7:0]);
    end
    checks++;
    if (irq !== irqM[0]) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%0d", tag, irq, irqM);
    end
    clearIns();
  endtask

  task automatic look(string tag, bit addr, int exp);
    busAddr = addr; #0;
    checks++;
    if (busRdata !== exp[7:0]) begin
      errors++;
      $display("FAIL %s readback actual=%h expected=%h", tag, busRdata, exp[7:0]);
    end
  endtask

  initial begin
    busAddr = 0;
    tick("R1"); tick("R1");
    rstN = 1;
    tick("R1");
    look("R1", 0, 0); look("R1", 1, 0);
    // R3 mask write
    busAddr = 1; busWr = 1; busWdata = 8'h00; tick("R3");
    // R2 each event
    busAddr = 0; txRdyEvt = 2'b01; tick("R2");
    look("R2", 0, 8'h01);
    rxRdyEvt = 2'b10; tick("R2"); look("R2", 0, 8'h21);
    brkChgEvt = 2'b11; tick("R2"); look("R2", 0, 8'h65);
    ctrRdyEvt = 1; portChgEvt = 1; tick("R2"); look("R2", 0, 8'hED);
    txRdyEvt = 2'b10; rxRdyEvt = 2'b01; tick("R2"); look("R2", 0, 8'hFF);
    // R3 status write ignored
    busAddr = 0; busWr = 1; busWdata = 8'h00; tick("R3"); look("R3", 0, 8'hFF);
    // R4 rx read clear
    rxReadStb = 2'b01; tick("R4"); look("R4", 0, 8'hFD);
    rxReadStb = 2'b10; tick("R4"); look("R4", 0, 8'hDD);
    // R5 break clear
    brkClrCmd = 2'b10; tick("R5"); look("R5", 0, 8'h9D);
    brkClrCmd = 2'b01; tick("R5"); look("R5", 0, 8'h99);
    // R6
    chgReadStb = 1; tick("R6"); look("R6", 0, 8'h19);
    ctrClrStb = 1; tick("R6"); look("R6", 0, 8'h11);
    // R10 tx pending, mask tx bits, tx disabled
    txEnable = 2'b00; busAddr = 1; busWr = 1; busWdata = 8'h11; tick("R10");
    tick("R10"); tick("R10");
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R10 irq actual=%b expected=0", irq); end
    // R9 enable channel B transmitter
    txEnable = 2'b10; tick("R9"); tick("R9");
    checks++;
    if (irq !== 1'b1) begin errors++; $display("FAIL R9 irq actual=%b expected=1", irq); end
    look("R3", 1, 8'h11);
    // R7 tx clear
    busAddr = 0; txBusyStb = 2'b10; tick("R7"); look("R7", 0, 8'h01);
    tick("R9");
    txBusyStb = 2'b01; tick("R7"); look("R7", 0, 8'h00);
    // R8 set wins
    rxRdyEvt = 2'b01; rxReadStb = 2'b01; tick("R8"); look("R8", 0, 8'h02);
    ctrRdyEvt = 1; ctrClrStb = 1; brkChgEvt = 2'b10; brkClrCmd = 2'b10; tick("R8");
    look("R8", 0, 8'h4A);
    // R9 mask those, irq follows
    busAddr = 1; busWr = 1; busWdata = 8'h08; tick("R9"); tick("R9"); tick("R9");
    busAddr = 1; busWr = 1; busWdata = 8'h00; tick("R9"); tick("R9");
    // R1 reset again
    rstN = 0; tick("R1"); rstN = 1; tick("R1");
    look("R1", 0, 0); look("R1", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule